// File: doc/BRIEF.md
# Transmit Outcome Status Tracker

This block follows one outgoing frame from its start request to its final outcome and keeps the result in an 8-bit status word. A start pulse opens a new frame and clears the word. Each attempt of that frame is marked by a high transmit-active level. Collisions, loss of carrier and the final done pulse are recorded as they arrive. A bit-time tick, one per bit at 10 Mb/s, drives two windows. The first is a slot window measured from the start of each attempt. It separates collisions seen within 512 bit times of the attempt start from late ones. The second is a short window after the done pulse, in which the transceiver must answer with a heartbeat collision signal.

Collisions are counted per frame. Every collision below the attempt limit asks the surrounding logic for a retry through a one-cycle pulse. The collision that reaches the limit aborts the frame and asks for no retry. Backoff timing and the data path stay outside the block.

Top module: `tx_outcome_tracker`

## Requirements
- R1: After reset the status word reads 0x22 and retry_req is low. Bit 5 and bit 1 of the word read as 1 at all times.
- R2: A tx_start pulse returns the word to 0x22 on the following cycle and clears the per-frame collision count. Without a new tx_start, every status bit keeps its value.
- R3: A collision is a rising edge of col_det while tx_active is high. The first collision of a frame sets bit 2. Each collision below the limit of 16 drives retry_req high for exactly the one cycle that follows the edge.
- R4: Elapsed time is the number of bit_tick pulses since the last rising edge of tx_active, with a tick in the same cycle as the collision included. A collision with more than 512 elapsed ticks sets bit 7. A collision with exactly 512 elapsed ticks does not set it.
- R5: A late collision (bit 7 case) still produces the retry pulse, the same as an in-window collision.
- R6: The 16th collision of a frame sets bit 3 and produces no retry pulse. Later collisions in the same frame change nothing and produce no retry pulse.
- R7: A falling edge of crs while tx_active is high sets bit 4.
- R8: A tx_done pulse sets bit 0 only when bits 7, 4 and 3 are all clear at that time.
- R9: After tx_done, if col_det is not high before the 64th bit_tick, bit 6 is set when that tick arrives. If col_det is high earlier, or in the same cycle as that tick, bit 6 stays clear. A col_det level while tx_active is low does not count as a collision.
- R10: The slot window starts again at every rising edge of tx_active. Ticks counted in earlier attempts of the same frame do not add to a later attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Pulse that opens a new frame |
| tx_active | input | 1 | High while an attempt is on the wire |
| tx_done | input | 1 | Pulse when the frame has been sent |
| col_det | input | 1 | Collision-detect level from the transceiver |
| crs | input | 1 | Carrier-sense level |
| bit_tick | input | 1 | One pulse per bit time |
| tx_status | output | 8 | Status word: 7 late collision, 6 heartbeat missing, 5 one, 4 carrier lost, 3 aborted, 2 collided, 1 one, 0 sent clean |
| retry_req | output | 1 | One-cycle retry request after a collision below the limit |

## Verification
Collision timing is driven at the slot boundary from both sides. A collision with 511 ticks plus a tick in the same cycle must stay in-window, while 512 ticks plus a tick must be late. Multi-attempt frames whose ticks add up past 512 show whether the slot timer restarts at each attempt. Frames with 16 and 17 collisions separate the abort path from the retry path and confirm that nothing changes after an abort. Heartbeat answers arrive after 63 ticks, after 64 ticks, or not at all, which places the window edge exactly. Randomly mixed frames with carrier drops and random collision counts and timing then exercise how the status bits combine.

// File: rtl/tx_outcome_pkg.sv
package tx_outcome_pkg;

  // Status word layout; bit order is visible to software and fixed.
  typedef struct packed {
    logic late_col;   // 7
    logic hb_miss;    // 6
    logic one_hi;     // 5
    logic crs_lost;   // 4
    logic aborted;    // 3
    logic collided;   // 2
    logic one_lo;     // 1
    logic sent_ok;    // 0
  } tx_stat_t;

  localparam tx_stat_t STAT_IDLE = '{
    late_col: 1'b0, hb_miss: 1'b0, one_hi: 1'b1, crs_lost: 1'b0,
    aborted: 1'b0, collided: 1'b0, one_lo: 1'b1, sent_ok: 1'b0
  };

  // A frame ends clean only without late collision, carrier loss or abort.
  function automatic logic clean_finish(tx_stat_t s);
    return !(s.late_col || s.crs_lost || s.aborted);
  endfunction

endpackage

// File: rtl/slot_window_timer.sv
module slot_window_timer #(
  parameter int SLOT_TICKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tx_active,
  input  logic bit_tick,
  output logic late
);
  localparam int CW = $clog2(SLOT_TICKS + 2);
  localparam logic [CW-1:0] SAT = CW'(SLOT_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          act_rise;
  logic [CW:0]   elapsed;

  // Ticks seen by this attempt, counting a tick in the current cycle.
  function automatic logic [CW:0] elapsed_now(logic [CW-1:0] c, logic rise,
                                               logic act, logic tk);
    logic [CW-1:0] base;
    logic          inc;
    base = rise ? '0 : c;
    inc  = act & tk & ~rise;
    return {1'b0, base} + {{CW{1'b0}}, inc};
  endfunction

  assign act_rise = tx_active & ~act_q;
  assign elapsed  = elapsed_now(cnt_q, act_rise, tx_active, bit_tick);
  assign late     = elapsed > (CW+1)'(SLOT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= tx_active;
      if (clear || act_rise)
        cnt_q <= '0;
      else if (tx_active && bit_tick && cnt_q != SAT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_rise |=> (cnt_q == '0));

endmodule

// File: rtl/collision_tally.sv
module collision_tally #(
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic col_event,
  output logic accepted,
  output logic limit_hit,
  output logic retry_req
);
  localparam int NW = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [NW-1:0] LIMIT = NW'(MAX_ATTEMPTS);

  logic [NW-1:0] n_q;
  logic          retry_q;

  function automatic logic is_last(logic [NW-1:0] n);
    return n == LIMIT - 1'b1;
  endfunction

  assign accepted  = col_event && (n_q < LIMIT);
  assign limit_hit = accepted && is_last(n_q);
  assign retry_req = retry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '0;
      retry_q <= 1'b0;
    end else if (clear) begin
      n_q     <= '0;
      retry_q <= 1'b0;
    end else begin
      retry_q <= accepted && !limit_hit;
      if (accepted) n_q <= n_q + 1'b1;
    end
  end

  // R6
  no_retry_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |=> !retry_req);

  // R3
  retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);

endmodule

// File: rtl/heartbeat_monitor.sv
module heartbeat_monitor #(
  parameter int HB_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic arm,
  input  logic col_det,
  input  logic bit_tick,
  output logic fail
);
  localparam int HW = $clog2(HB_TICKS + 1);
  localparam logic [HW-1:0] LAST = HW'(HB_TICKS - 1);

  logic          open_q;
  logic [HW-1:0] cnt_q;

  assign fail = open_q && !clear && !arm && !col_det && bit_tick && cnt_q == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (open_q) begin
      if (col_det)
        open_q <= 1'b0;
      else if (bit_tick) begin
        if (cnt_q == LAST) open_q <= 1'b0;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R9
  fail_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> open_q);

  // R9
  arm_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !clear) |=> open_q);

endmodule

// File: rtl/tx_outcome_tracker.sv
module tx_outcome_tracker
  import tx_outcome_pkg::*;
#(
  parameter int SLOT_TICKS   = 512,
  parameter int HB_TICKS     = 64,
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_start,
  input  logic       tx_active,
  input  logic       tx_done,
  input  logic       col_det,
  input  logic       crs,
  input  logic       bit_tick,
  output logic [7:0] tx_status,
  output logic       retry_req
);
  tx_stat_t stat_q;
  logic     col_q, crs_q;
  logic     col_event, crs_drop, slot_late;
  logic     col_taken, abort_hit, hb_fail;

  assign col_event = tx_active & col_det & ~col_q & ~tx_start;
  assign crs_drop  = tx_active & crs_q & ~crs;

  slot_window_timer #(.SLOT_TICKS(SLOT_TICKS)) u_slot (
    .clk(clk), .rst_n(rst_n), .clear(tx_start), .tx_active(tx_active),
    .bit_tick(bit_tick), .late(slot_late));

  collision_tally #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(tx_start), .col_event(col_event),
    .accepted(col_taken), .limit_hit(abort_hit), .retry_req(retry_req));

  heartbeat_monitor #(.HB_TICKS(HB_TICKS)) u_hb (
    .clk(clk), .rst_n(rst_n), .clear(tx_start), .arm(tx_done & ~tx_start),
    .col_det(col_det), .bit_tick(bit_tick), .fail(hb_fail));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= 1'b0;
      crs_q  <= 1'b0;
      stat_q <= STAT_IDLE;
    end else begin
      col_q <= col_det;
      crs_q <= crs;
      if (tx_start) begin
        stat_q <= STAT_IDLE;
      end else begin
        if (col_taken) begin
          stat_q.collided <= 1'b1;
          if (slot_late) stat_q.late_col <= 1'b1;
          if (abort_hit) stat_q.aborted  <= 1'b1;
        end
        if (crs_drop) stat_q.crs_lost <= 1'b1;
        if (tx_done && clean_finish(stat_q)) stat_q.sent_ok <= 1'b1;
        if (hb_fail) stat_q.hb_miss <= 1'b1;
      end
    end
  end

  assign tx_status = stat_q;

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (tx_status == 8'h22));

  // R8
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_status[0]) |-> $past(tx_done));

  // R6
  abort_blocks_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_status[3] |-> !retry_req);

  // R4
  late_needs_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_status[7]) |-> $past(col_det && tx_active));

endmodule

// File: tb/tx_outcome_tracker_tb.sv
module tx_outcome_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n, tx_start, tx_active, tx_done, col_det, crs, bit_tick;
  logic [7:0] tx_status;
  logic retry_req;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tx_outcome_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_active(tx_active),
    .tx_done(tx_done), .col_det(col_det), .crs(crs), .bit_tick(bit_tick),
    .tx_status(tx_status), .retry_req(retry_req));

  // Expected word from the requirement-level outcome flags.
  function automatic logic [7:0] word_of(bit owc, bit hb, bit cl, bit ab,
                                         bit co, bit ok);
    logic [7:0] w;
    w = 8'h22;
    if (ok)  w = w | 8'h01;
    if (co)  w = w | 8'h04;
    if (ab)  w = w | 8'h08;
    if (cl)  w = w | 8'h10;
    if (hb)  w = w | 8'h40;
    if (owc) w = w | 8'h80;
    return w;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; step();
    end
    bit_tick = 1'b0;
  endtask

  // mode: 0 early, 1 late, 2 random mix, 3 511+tick, 4 512+tick, 5 400 each
  task automatic run_frame(int n, int mode, bit drop_crs, int hb_delay);
    bit e_owc = 0, e_hb = 0, e_cl = 0, e_ab = 0, e_co = 0, e_ok = 0;
    logic [7:0] held;
    tx_start = 1'b1; step(); tx_start = 1'b0;
    check("R2 start clears", tx_status, 8'h22);
    for (int k = 1; k <= n; k++) begin
      int t; bit w; bit lt;
      w = 0;
      case (mode)
        0: t = $urandom_range(1, 120);
        1: t = $urandom_range(513, 530);
        2: t = ($urandom_range(0, 1) != 0) ? $urandom_range(513, 530) : $urandom_range(1, 120);
        3: begin t = 511; w = 1; end
        4: begin t = 512; w = 1; end
        default: t = 400;
      endcase
      lt = (t + int'(w)) > 512;
      tx_active = 1'b1; step();
      ticks(t);
      col_det = 1'b1; bit_tick = w; step();
      col_det = 1'b0; bit_tick = 1'b0;
      if (k <= 16) begin
        e_co = 1;
        if (lt) e_owc = 1;
        if (k == 16) e_ab = 1;
      end
      if (k >= 16)      check("R6 no retry at or after limit", {7'd0, retry_req}, 8'd0);
      else if (lt)      check("R5 late collision retries", {7'd0, retry_req}, 8'd1);
      else              check("R3 retry pulse", {7'd0, retry_req}, 8'd1);
      if (mode == 3 || mode == 4 || lt)
        check("R4 slot boundary", tx_status, word_of(e_owc, 0, 0, e_ab, e_co, 0));
      else if (mode == 5)
        check("R10 slot restarts", tx_status, word_of(e_owc, 0, 0, e_ab, e_co, 0));
      else
        check("R3 collided bit", tx_status, word_of(e_owc, 0, 0, e_ab, e_co, 0));
      tx_active = 1'b0; step();
      check("R3 retry one cycle", {7'd0, retry_req}, 8'd0);
    end
    if (n < 16) begin
      tx_active = 1'b1; step();
      ticks(10);
      if (drop_crs) begin
        crs = 1'b0; step(); crs = 1'b1;
        e_cl = 1;
        check("R7 carrier lost", tx_status, word_of(e_owc, 0, e_cl, 0, e_co, 0));
      end
      ticks(5);
      tx_active = 1'b0; tx_done = 1'b1; step(); tx_done = 1'b0;
      e_ok = !(e_owc || e_cl || e_ab);
      check("R8 done outcome", tx_status, word_of(e_owc, 0, e_cl, 0, e_co, e_ok));
      ticks(hb_delay);
      if (hb_delay >= 64) e_hb = 1;
      if (hb_delay < 64) begin
        col_det = 1'b1; step(); col_det = 1'b0;
      end
      ticks(70);
      check("R9 heartbeat window", tx_status, word_of(e_owc, e_hb, e_cl, 0, e_co, e_ok));
    end else begin
      ticks(70);
      check("R6 abort state", tx_status, word_of(e_owc, 0, 0, 1, 1, 0));
    end
    held = tx_status;
    ticks(5); step(); step();
    check("R2 bits hold", tx_status, held);
    check("R1 constant ones", tx_status & 8'h22, 8'h22);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tx_start = 1'b0; tx_active = 1'b0; tx_done = 1'b0;
    col_det = 1'b0; crs = 1'b1; bit_tick = 1'b0;
    step(); step(); step();
    rst_n = 1'b1; step();
    check("R1 reset word", tx_status, 8'h22);
    check("R1 reset retry", {7'd0, retry_req}, 8'd0);

    run_frame(0, 0, 0, 10);   // clean frame, heartbeat answered
    run_frame(1, 0, 0, 63);   // heartbeat at last allowed tick
    run_frame(0, 0, 0, 64);   // heartbeat too late
    run_frame(0, 0, 0, 80);   // heartbeat absent
    run_frame(0, 0, 1, 5);    // carrier dropped
    run_frame(1, 3, 0, 5);    // exactly 512 elapsed: in window
    run_frame(1, 4, 0, 5);    // 513 elapsed: late
    run_frame(3, 5, 0, 5);    // attempts add past 512, each in window
    run_frame(2, 1, 1, 20);   // late plus carrier loss
    run_frame(16, 0, 0, 5);   // abort at limit
    run_frame(17, 0, 0, 5);   // collision after abort ignored

    for (int f = 0; f < 10; f++) begin
      int n  = $urandom_range(0, 5);
      int md = $urandom_range(0, 2);
      bit dc = ($urandom_range(0, 3) == 0);
      int hb = $urandom_range(0, 70);
      run_frame(n, md, dc, hb);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule